// File: doc/BRIEF.md
# External Interrupt Request Front-End

This block sits between the external interrupt pins of a small processor core and the core's interrupt entry logic. It takes one nonmaskable pin and nine maskable request pins and brings each into the system clock domain. For every maskable pin, software picks edge or level triggering and the active polarity. The block keeps one pending request per source. It applies the per-source masks and a global interrupt-enable flag. When the core raises its instruction-boundary strobe, the block presents one winning request as a single-cycle take pulse.

The nonmaskable source has no busy state and no mask, so a new edge on it can enter its handler again. A maskable source that has been taken is marked busy. It stays silent until the core acknowledges it by index. Every take clears the global enable, and software turns it back on through a set strobe.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, take_nmi and take_irq are low and gie is 0.
- R2: A rising edge on nmi_pin, even one only one clock high, is latched. It yields a take_nmi pulse at the next boundary strobe, whatever gie and the masks hold. Each latched edge gives exactly one take.
- R3: A pending nonmaskable request wins over every maskable request at a boundary. It is never blocked by busy maskable sources or by a previous nonmaskable take, and take_nmi and take_irq are never high together.
- R4: Every take, nonmaskable or maskable, clears gie. A gie_set strobe sets gie again. While gie is 0, no maskable request is presented, and the request stays pending.
- R5: In edge mode (cfg_level bit 0), a change of a pin from its inactive to its active level is latched, even when the active level is held for only one clock. The request stays pending after the pin returns to inactive.
- R6: cfg_active_low bit 1 makes the low pin level the active one. Changing the pin and its polarity bit in the same cycle creates no edge.
- R7: In level mode (cfg_level bit 1), the request follows the synchronized active level and is not latched. A pulse that ends before the boundary produces no take.
- R8: When several unmasked maskable sources are pending, the lowest-numbered one wins. Its index is given on the 4-bit take_idx as an unsigned binary number (0 to 8).
- R9: After a maskable take, that source is busy. Edges from it are ignored and not stored, and its level request is not presented, until an ack with ack_idx equal to that source's index arrives.
- R10: A source whose cfg_mask bit is 1 is never taken. An edge that arrives while the source is masked is still latched and is taken after the source is unmasked.
- R11: take_nmi and take_irq are one-cycle pulses, registered on the clock edge at which boundary is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Nonmaskable request pin, rising edge active |
| irq_pin | input | 9 | Maskable request pins, asynchronous |
| cfg_level | input | 9 | Per source: 1 = level mode, 0 = edge mode |
| cfg_active_low | input | 9 | Per source: 1 = low level is active |
| cfg_mask | input | 9 | Per source: 1 = masked |
| gie_set | input | 1 | Software strobe that sets the global enable |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ack | input | 1 | Acknowledge strobe from the core |
| ack_idx | input | 4 | Index of the acknowledged maskable source |
| take_nmi | output | 1 | Pulse: nonmaskable interrupt taken |
| take_irq | output | 1 | Pulse: maskable interrupt taken |
| take_idx | output | 4 | Index of the taken maskable source |
| gie | output | 1 | Global interrupt-enable flag |

## Verification
The bench targets the corner cases where a front-end most often goes wrong.

Single-clock pulses check capture: a design that sampled too slowly would lose them and never take. A repeated edge from a busy source is applied, then acked. A design that re-armed early would take twice, and one that queued the edge would take after the ack with no new edge.

A level pulse that ends before the boundary must produce no take, which a latching design would get wrong. The pin and its polarity are flipped together, and a design that inverted after synchronizing would see a false edge.

A nonmaskable edge is raised alongside a maskable one, and lowest-index arbitration is checked, to catch wrong priority. A masked edge is raised and later unmasked, to catch a mask that either leaks or discards the edge.

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
  parameter int NUM_SRC = 9,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pin,
  input  logic [NUM_SRC-1:0] irq_pin,
  input  logic [NUM_SRC-1:0] cfg_level,
  input  logic [NUM_SRC-1:0] cfg_active_low,
  input  logic [NUM_SRC-1:0] cfg_mask,
  input  logic               gie_set,
  input  logic               boundary,
  input  logic               ack,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic               take_nmi,
  output logic               take_irq,
  output logic [IDX_W-1:0]   take_idx,
  output logic               gie
);

  logic [NUM_SRC-1:0] act_s1, act_s2, act_s3;
  logic               nmi_s1, nmi_s2, nmi_s3;
  logic               nmi_pend;
  logic [NUM_SRC-1:0] pend, busy;
  logic [NUM_SRC-1:0] rise, req, hit, ack_vec;
  logic [IDX_W-1:0]   win;
  logic               nmi_rise, nmi_go, irq_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_s1 <= '0;
      act_s2 <= '0;
      act_s3 <= '0;
      nmi_s1 <= 1'b0;
      nmi_s2 <= 1'b0;
      nmi_s3 <= 1'b0;
    end else begin
      act_s1 <= irq_pin ^ cfg_active_low;
      act_s2 <= act_s1;
      act_s3 <= act_s2;
      nmi_s1 <= nmi_pin;
      nmi_s2 <= nmi_s1;
      nmi_s3 <= nmi_s2;
    end
  end

  assign rise     = act_s2 & ~act_s3;
  assign nmi_rise = nmi_s2 & ~nmi_s3;

  assign req = ~busy & ~cfg_mask & ((cfg_level & act_s2) | (~cfg_level & pend));

  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (req[i]) win = IDX_W'(i);
  end

  assign nmi_go  = boundary & nmi_pend;
  assign irq_go  = boundary & ~nmi_pend & gie & (|req);
  assign hit     = irq_go ? (NUM_SRC'(1) << win) : '0;
  assign ack_vec = ack ? (NUM_SRC'(1) << ack_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      pend     <= '0;
      busy     <= '0;
      gie      <= 1'b0;
      take_nmi <= 1'b0;
      take_irq <= 1'b0;
      take_idx <= '0;
    end else begin
      nmi_pend <= (nmi_pend & ~boundary) | nmi_rise;
      pend     <= ~cfg_level & ((pend & ~hit) | (rise & ~busy & ~hit));
      busy     <= (busy | hit) & ~ack_vec;
      take_nmi <= nmi_go;
      take_irq <= irq_go;
      if (irq_go) take_idx <= win;
      if (nmi_go || irq_go) gie <= 1'b0;
      else if (gie_set)     gie <= 1'b1;
    end
  end

  AST_TAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_nmi && take_irq)); // R3
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(gie)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (int'(take_idx) < NUM_SRC)); // R8
  AST_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (($past(cfg_mask) >> take_idx) & NUM_SRC'(1)) == '0); // R10
  AST_NO_RETAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (($past(busy) >> take_idx) & NUM_SRC'(1)) == '0); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R11
  AST_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq || take_nmi) |-> $past(boundary)); // R11

endmodule

// File: tb/ext_irq_front_tb.sv
`timescale 1ns/1ps
module ext_irq_front_tb;
  localparam int N = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_pin = 1'b0;
  logic [N-1:0] irq_pin = '0, cfg_level = '0, cfg_active_low = '0, cfg_mask = '0;
  logic gie_set = 1'b0, boundary = 1'b0, ack = 1'b0;
  logic [3:0] ack_idx = '0;
  logic take_nmi, take_irq, gie;
  logic [3:0] take_idx;
  int total = 0, bad = 0;
  logic s_nmi, s_irq;
  logic [3:0] s_idx;

  always #5 clk = ~clk;

  ext_irq_front #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .cfg_level(cfg_level), .cfg_active_low(cfg_active_low), .cfg_mask(cfg_mask),
    .gie_set(gie_set), .boundary(boundary), .ack(ack), .ack_idx(ack_idx),
    .take_nmi(take_nmi), .take_irq(take_irq), .take_idx(take_idx), .gie(gie)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0;
    s_nmi = take_nmi; s_irq = take_irq; s_idx = take_idx;
  endtask

  task automatic enable();
    @(negedge clk) gie_set = 1'b1;
    @(negedge clk) gie_set = 1'b0;
  endtask

  task automatic do_ack(input int i);
    @(negedge clk) begin ack = 1'b1; ack_idx = 4'(i); end
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic pulse_irq(input int i);
    @(negedge clk) irq_pin[i] = ~irq_pin[i];
    @(negedge clk) irq_pin[i] = ~irq_pin[i];
    settle();
  endtask

  task automatic pulse_nmi();
    @(negedge clk) nmi_pin = 1'b1;
    @(negedge clk) nmi_pin = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    check("R1 take_nmi", take_nmi, 0);
    check("R1 take_irq", take_irq, 0);
    check("R1 gie", gie, 0);
  endtask

  task automatic t_nmi();
    pulse_nmi();
    strobe();
    check("R2 nmi taken with gie=0", s_nmi, 1);
    strobe();
    check("R2 single take per edge", s_nmi, 0);
    pulse_nmi();
    strobe();
    check("R3 nmi re-entry", s_nmi, 1);
  endtask

  task automatic t_edge();
    enable();
    pulse_irq(5);
    strobe();
    check("R5 edge taken", s_irq, 1);
    check("R5 index", s_idx, 5);
    check("R4 gie cleared", gie, 0);
    @(negedge clk);
    check("R11 one-cycle pulse", take_irq, 0);
    do_ack(5);
  endtask

  task automatic t_gie();
    pulse_irq(2);
    strobe();
    check("R4 blocked while gie=0", s_irq, 0);
    enable();
    strobe();
    check("R4 kept pending then taken", s_irq, 1);
    check("R4 index", s_idx, 2);
    do_ack(2);
  endtask

  task automatic t_prio();
    fork pulse_irq(7); pulse_irq(4); join
    enable();
    strobe();
    check("R8 lowest wins", s_idx, 4);
    do_ack(4);
    enable();
    strobe();
    check("R8 next source", s_idx, 7);
    check("R8 taken", s_irq, 1);
    do_ack(7);
  endtask

  task automatic t_nmi_over();
    fork pulse_irq(1); pulse_nmi(); join
    enable();
    strobe();
    check("R3 nmi wins", s_nmi, 1);
    check("R3 maskable held off", s_irq, 0);
    enable();
    strobe();
    check("R3 maskable after nmi", s_irq, 1);
    check("R3 index", s_idx, 1);
    do_ack(1);
  endtask

  task automatic t_busy();
    enable();
    pulse_irq(6);
    strobe();
    check("R9 first take", s_irq, 1);
    pulse_irq(6);
    enable();
    strobe();
    check("R9 busy ignores edge", s_irq, 0);
    do_ack(6);
    strobe();
    check("R9 ignored edge not stored", s_irq, 0);
    pulse_irq(6);
    strobe();
    check("R9 rearmed after ack", s_irq, 1);
    check("R9 index", s_idx, 6);
    do_ack(6);
  endtask

  task automatic t_level();
    @(negedge clk) cfg_level[3] = 1'b1;
    @(negedge clk) irq_pin[3] = 1'b1;
    settle();
    enable();
    strobe();
    check("R7 level taken", s_irq, 1);
    check("R7 index", s_idx, 3);
    enable();
    strobe();
    check("R9 level busy", s_irq, 0);
    do_ack(3);
    strobe();
    check("R7 level persists", s_irq, 1);
    do_ack(3);
    @(negedge clk) irq_pin[3] = 1'b0;
    settle();
    pulse_irq(3);
    enable();
    strobe();
    check("R7 short pulse not latched", s_irq, 0);
    @(negedge clk) cfg_level[3] = 1'b0;
  endtask

  task automatic t_polarity();
    @(negedge clk) begin irq_pin[8] = 1'b1; cfg_active_low[8] = 1'b1; end
    settle();
    strobe();
    check("R6 no edge on joint change", s_irq, 0);
    pulse_irq(8);
    strobe();
    check("R6 low level active", s_irq, 1);
    check("R6 index 8", s_idx, 8);
    do_ack(8);
    @(negedge clk) begin irq_pin[8] = 1'b0; cfg_active_low[8] = 1'b0; end
    settle();
  endtask

  task automatic t_mask();
    @(negedge clk) cfg_mask[0] = 1'b1;
    enable();
    pulse_irq(0);
    strobe();
    check("R10 masked not taken", s_irq, 0);
    check("R10 gie untouched", gie, 1);
    @(negedge clk) cfg_mask[0] = 1'b0;
    strobe();
    check("R10 taken after unmask", s_irq, 1);
    check("R10 index", s_idx, 0);
    do_ack(0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nmi();
    t_edge();
    t_gie();
    t_prio();
    t_nmi_over();
    t_busy();
    t_level();
    t_polarity();
    t_mask();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule